// File: doc/BRIEF.md
# External Interrupt Controller

This block collects up to `NUM_LINES` external interrupt lines and merges them into one interrupt request for the processor. Lines are grouped 32 to a word: line n is bit n%32 of word n/32. Each line has four stored controls: a mask, a sensitivity (level or edge), a polarity (high/rising or low/falling) and a software-raised pending bit. Each line also has a domain-enable bit that admits it to the processor. An edge-sensitive line keeps a latched pending flag until software acknowledges it. A level-sensitive line reports its pin state directly.

Software changes the mask, sensitivity, polarity and software-pending bits through write-one-to-set and write-one-to-clear aliases, so a single line can be updated without a read-modify-write. The domain enables are written as whole words and are expected to be filled with ones during initialisation. Detecting both edges is left to software: it swaps the polarity after each event and, if it may have missed an edge, raises the software-pending bit. That bit therefore feeds the status directly.

The register port takes a word address `regAddr` (byte offset divided by 4). Bits [8:5] select the register kind and bits [4:0] select the word. Writes take effect on the clock edge where `regWe` is high. Reads are combinational.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Line n is bit n%32 of word n/32 in every register kind. The word index is `regAddr[4:0]` and the kind is `regAddr[8:5]`. Bits for lines at or above `NUM_LINES` read as 0.
- R2: After reset, every implemented line is masked (mask reads 1), edge-sensitive (sensitivity 0) and low polarity (polarity 0). No software pending bit is set, status reads 0 and `irqOut` is 0.
- R3: Kind codes 3/4 set/clear mask, 6/7 set/clear sensitivity, 9/10 set/clear polarity and 12/13 set/clear software pending. In each case only the bits written as 1 change. Kinds 2, 5, 8 and 11 read back the mask, sensitivity, polarity and software pending bits.
- R4: With sensitivity 1 (level), the status bit is 1 exactly while the synchronised input equals the polarity bit. It follows the pin two clock edges after a change.
- R5: With sensitivity 0 (edge), a rising transition (polarity 1) or a falling transition (polarity 0) latches the status bit. The bit stays set after the pin returns, until a 1 is written to the acknowledge kind (code 1) for that bit.
- R6: Changing the polarity while the pin is steady never latches an edge.
- R7: A software pending bit forces the line's status to 1, whatever the pin and the sensitivity, until it is cleared.
- R8: The status bit is 0 while the line's domain-enable bit is 0. Kind 14 writes and reads the domain-enable word.
- R9: `irqOut` is 1 exactly when some line has status 1 and mask 0. Status reads at kind 0.
- R10: A write leaves every register unchanged when it targets a word index at or above the number of words, a read-only kind (0, 2, 5, 8, 11) or kind 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | NUM_LINES | External interrupt lines, asynchronous |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 9 | Word address: kind in [8:5], word index in [4:0] |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Combined interrupt request to the processor |

## Verification
The bench builds the block with `NUM_LINES` = 40. The second word then holds only eight real lines, which tests that unimplemented bits read as zero and stay immune to set writes. Word index 2 becomes an out-of-range target, which exercises the write-rejection path. Line 33 sits in the partial word and carries the edge and polarity cases, so a slip in the word/bit split shows up on the status of the wrong word.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int REG_ADDR_W = 9;
  localparam int WORD_IDX_W = 5;

  typedef enum logic [3:0] {
    K_STAT     = 4'd0,
    K_ACK      = 4'd1,
    K_MASK     = 4'd2,
    K_MASK_SET = 4'd3,
    K_MASK_CLR = 4'd4,
    K_SENS     = 4'd5,
    K_SENS_SET = 4'd6,
    K_SENS_CLR = 4'd7,
    K_POL      = 4'd8,
    K_POL_SET  = 4'd9,
    K_POL_CLR  = 4'd10,
    K_SOFT     = 4'd11,
    K_SOFT_SET = 4'd12,
    K_SOFT_CLR = 4'd13,
    K_DOM      = 4'd14,
    K_RSVD     = 4'd15
  } regKind_e;

  typedef enum logic [3:0] {
    OP_NONE, OP_ACK,
    OP_MASK_SET, OP_MASK_CLR,
    OP_SENS_SET, OP_SENS_CLR,
    OP_POL_SET, OP_POL_CLR,
    OP_SOFT_SET, OP_SOFT_CLR,
    OP_DOM_WR
  } wrOp_e;

  typedef struct packed {
    wrOp_e                 op;
    logic [WORD_IDX_W-1:0] word;
    logic [31:0]           data;
  } wrStrobe_t;

endpackage

// File: rtl/ext_irq_decode.sv
module ext_irq_decode
  import ext_irq_pkg::*;
#(
  parameter int NWORDS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWdata,
  output wrStrobe_t             wrStrobe,
  output regKind_e              rdKind,
  output logic [WORD_IDX_W-1:0] rdWord
);

  regKind_e              kind;
  logic [WORD_IDX_W-1:0] word;
  logic                  wordOk;

  assign kind   = regKind_e'(regAddr[REG_ADDR_W-1:WORD_IDX_W]);
  assign word   = regAddr[WORD_IDX_W-1:0];
  assign wordOk = (int'(word) < NWORDS);
  assign rdKind = kind;
  assign rdWord = word;

  always_comb begin
    wrStrobe.op   = OP_NONE;
    wrStrobe.word = word;
    wrStrobe.data = regWdata;
    if (regWe && wordOk) begin
      unique case (kind)
        K_ACK:      wrStrobe.op = OP_ACK;
        K_MASK_SET: wrStrobe.op = OP_MASK_SET;
        K_MASK_CLR: wrStrobe.op = OP_MASK_CLR;
        K_SENS_SET: wrStrobe.op = OP_SENS_SET;
        K_SENS_CLR: wrStrobe.op = OP_SENS_CLR;
        K_POL_SET:  wrStrobe.op = OP_POL_SET;
        K_POL_CLR:  wrStrobe.op = OP_POL_CLR;
        K_SOFT_SET: wrStrobe.op = OP_SOFT_SET;
        K_SOFT_CLR: wrStrobe.op = OP_SOFT_CLR;
        K_DOM:      wrStrobe.op = OP_DOM_WR;
        default:    wrStrobe.op = OP_NONE;
      endcase
    end
  end

  // R10: no strobe leaves the decoder without a bus write
  a_r10_idle_no_op : assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> (wrStrobe.op == OP_NONE));

endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NWORDS    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  wrStrobe_t             wrStrobe,
  input  regKind_e              rdKind,
  input  logic [WORD_IDX_W-1:0] rdWord,
  output logic [31:0]           rdData,
  output logic                  irqOut
);

  localparam int WIDE = NWORDS * 32;

  logic [NUM_LINES-1:0] maskQ, sensQ, polQ, softQ, domQ, latchQ;
  logic [NUM_LINES-1:0] metaQ, syncQ, prevQ;
  logic [NUM_LINES-1:0] wrVec, selVec, edgeHit, levelHit, statusVec, ackVec;

  always_comb begin
    wrVec  = '0;
    selVec = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (wrStrobe.word == WORD_IDX_W'(n / 32)) begin
        selVec[n] = 1'b1;
        wrVec[n]  = wrStrobe.data[n % 32];
      end
    end
  end

  assign ackVec    = (wrStrobe.op == OP_ACK) ? wrVec : '0;
  assign edgeHit   = (polQ & syncQ & ~prevQ) | (~polQ & ~syncQ & prevQ);
  assign levelHit  = ~(syncQ ^ polQ);
  assign statusVec = domQ & ((latchQ & ~sensQ) | (levelHit & sensQ) | softQ);
  assign irqOut    = |(statusVec & ~maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ  <= '0;
      syncQ  <= '0;
      prevQ  <= '0;
      latchQ <= '0;
    end else begin
      metaQ  <= lineIn;
      syncQ  <= metaQ;
      prevQ  <= syncQ;
      latchQ <= (latchQ & ~ackVec) | (edgeHit & ~sensQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      sensQ <= '0;
      polQ  <= '0;
      softQ <= '0;
      domQ  <= '0;
    end else begin
      unique case (wrStrobe.op)
        OP_MASK_SET: maskQ <= maskQ | wrVec;
        OP_MASK_CLR: maskQ <= maskQ & ~wrVec;
        OP_SENS_SET: sensQ <= sensQ | wrVec;
        OP_SENS_CLR: sensQ <= sensQ & ~wrVec;
        OP_POL_SET:  polQ  <= polQ | wrVec;
        OP_POL_CLR:  polQ  <= polQ & ~wrVec;
        OP_SOFT_SET: softQ <= softQ | wrVec;
        OP_SOFT_CLR: softQ <= softQ & ~wrVec;
        OP_DOM_WR:   domQ  <= (domQ & ~selVec) | wrVec;
        default: ;
      endcase
    end
  end

  logic [NUM_LINES-1:0] rdVec;
  logic [WIDE-1:0]      rdWide;

  always_comb begin
    unique case (rdKind)
      K_STAT:  rdVec = statusVec;
      K_MASK:  rdVec = maskQ;
      K_SENS:  rdVec = sensQ;
      K_POL:   rdVec = polQ;
      K_SOFT:  rdVec = softQ;
      K_DOM:   rdVec = domQ;
      default: rdVec = '0;
    endcase
    rdWide = '0;
    rdWide[NUM_LINES-1:0] = rdVec;
    rdData = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (rdWord == WORD_IDX_W'(w)) rdData = rdWide[w*32 +: 32];
    end
  end

  // R6, R5: a latch bit only rises after a real pin transition
  a_r6_no_spurious_latch : assert property (@(posedge clk) disable iff (!rstN)
    ((latchQ & ~$past(latchQ) & ~$past(syncQ ^ prevQ)) == '0));

  // R7: a pending software bit is always visible in status when admitted
  a_r7_soft_pending : assert property (@(posedge clk) disable iff (!rstN)
    ((softQ & domQ & ~statusVec) == '0));

  // R8: a line outside the domain never shows status
  a_r8_domain_gate : assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & ~domQ) == '0));

  // R9: with every line masked the request stays low
  a_r9_mask_blocks : assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut);

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  output logic                  irqOut
);

  localparam int NWORDS = (NUM_LINES + 31) / 32;

  wrStrobe_t             wrStrobe;
  regKind_e              rdKind;
  logic [WORD_IDX_W-1:0] rdWord;

  ext_irq_decode #(.NWORDS(NWORDS)) decode_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .wrStrobe (wrStrobe),
    .rdKind   (rdKind),
    .rdWord   (rdWord)
  );

  ext_irq_datapath #(.NUM_LINES(NUM_LINES), .NWORDS(NWORDS)) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .wrStrobe (wrStrobe),
    .rdKind   (rdKind),
    .rdWord   (rdWord),
    .rdData   (regRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;

  localparam int N  = 40;
  localparam int NW = (N + 31) / 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] lineIn = '0;
  logic         regWe = 1'b0;
  logic [8:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic         irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] mMask = '1, mSens = '0, mPol = '0, mSoft = '0, mDom = '0;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] wordOf(logic [N-1:0] v, int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) if (w * 32 + b < N) r[b] = v[w * 32 + b];
    return r;
  endfunction

  function automatic logic [N-1:0] modelStatus();
    return mDom & (mSoft | (mSens & ~(lineIn ^ mPol)));
  endfunction

  function automatic void modelApply(int kind, int w, logic [31:0] d);
    logic [N-1:0] v = '0, s = '0;
    if (w >= NW) return;
    for (int n = 0; n < N; n++) if (n / 32 == w) begin s[n] = 1'b1; v[n] = d[n % 32]; end
    case (kind)
      3:  mMask = mMask | v;   4: mMask = mMask & ~v;
      6:  mSens = mSens | v;   7: mSens = mSens & ~v;
      9:  mPol  = mPol | v;   10: mPol  = mPol & ~v;
      12: mSoft = mSoft | v;  13: mSoft = mSoft & ~v;
      14: mDom  = (mDom & ~s) | v;
      default: ;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int kind, int w, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = {kind[3:0], w[4:0]}; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    modelApply(kind, w, d);
  endtask

  task automatic rd(int kind, int w, output logic [31:0] d);
    @(negedge clk);
    regAddr = {kind[3:0], w[4:0]};
    #1 d = regRdata;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1d5e_a7c3));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R2 reset state
    rd(2, 0, d); chk("R2 mask w0", d, 32'hFFFF_FFFF);
    rd(2, 1, d); chk("R2 mask w1 (R1 padding)", d, 32'h0000_00FF);
    rd(5, 0, d); chk("R2 sens w0", d, 0);
    rd(8, 1, d); chk("R2 pol w1", d, 0);
    rd(0, 0, d); chk("R2 status w0", d, 0);
    chk("R2 irq", irqOut, 0);

    wr(14, 0, 32'hFFFF_FFFF); wr(14, 1, 32'hFFFF_FFFF);
    rd(14, 1, d); chk("R8 dom w1 R1 padding", d, 32'h0000_00FF);

    // R3 set/clear aliases
    wr(4, 0, 32'h0000_F0F0); rd(2, 0, d); chk("R3 mask clr", d, 32'hFFFF_0F0F);
    wr(3, 0, 32'h0000_00F0); rd(2, 0, d); chk("R3 mask set", d, 32'hFFFF_0FFF);
    wr(3, 0, 32'h0);         rd(2, 0, d); chk("R3 zero write", d, 32'hFFFF_0FFF);

    // R4 level, line 5
    wr(6, 0, 32'h20); wr(9, 0, 32'h20); wr(4, 0, 32'h20);
    rd(5, 0, d); chk("R3 sens readback", d, 32'h20);
    lineIn[5] = 1'b1; waitCyc(3);
    rd(0, 0, d); chk("R4 level high", d, 32'h20);
    chk("R9 irq on level", irqOut, 1);
    lineIn[5] = 1'b0; waitCyc(3);
    rd(0, 0, d); chk("R4 level released", d, 0);
    chk("R9 irq off", irqOut, 0);
    wr(10, 0, 32'h20); rd(0, 0, d); chk("R4 active-low level", d, 32'h20);
    wr(7, 0, 32'h20); rd(0, 0, d); chk("R4 back to edge", d, 0);

    // R5 edge, line 33 = word 1 bit 1
    wr(9, 1, 32'h2);
    lineIn[33] = 1'b1; waitCyc(4);
    rd(0, 1, d); chk("R5 rising latched", d, 32'h2);
    rd(0, 0, d); chk("R1 other word clean", d, 0);
    lineIn[33] = 1'b0; waitCyc(4);
    rd(0, 1, d); chk("R5 held after return", d, 32'h2);
    wr(1, 1, 32'h2); rd(0, 1, d); chk("R5 ack clears", d, 0);
    wr(10, 1, 32'h2);
    lineIn[33] = 1'b1; waitCyc(4);
    rd(0, 1, d); chk("R5 rise ignored when falling", d, 0);
    lineIn[33] = 1'b0; waitCyc(4);
    rd(0, 1, d); chk("R5 falling latched", d, 32'h2);
    wr(1, 1, 32'h2); rd(0, 1, d); chk("R5 ack falling", d, 0);

    // R6 polarity flips with steady pin
    lineIn[33] = 1'b1; waitCyc(4);
    wr(9, 1, 32'h2); wr(10, 1, 32'h2); wr(9, 1, 32'h2); waitCyc(3);
    rd(0, 1, d); chk("R6 no latch on polarity flip", d, 0);
    lineIn[33] = 1'b0; waitCyc(4);
    wr(1, 1, 32'h2);

    // R7 software pending, line 10
    wr(12, 0, 32'h400); rd(0, 0, d); chk("R7 soft status", d, 32'h400);
    chk("R9 masked soft no irq", irqOut, 0);
    wr(4, 0, 32'h400); chk("R9 unmasked soft irq", irqOut, 1);
    wr(13, 0, 32'h400); rd(0, 0, d); chk("R7 soft clear", d, 0);
    chk("R7 irq after soft clear", irqOut, 0);

    // R8 domain gate
    wr(12, 0, 32'h400); wr(14, 0, ~32'h400);
    rd(0, 0, d); chk("R8 gated status", d, 0);
    chk("R8 gated irq", irqOut, 0);
    wr(14, 0, 32'hFFFF_FFFF); rd(0, 0, d); chk("R8 regated", d, 32'h400);
    wr(13, 0, 32'h400);

    // R10 ignored writes
    wr(0, 0, 32'hFFFF_FFFF); wr(2, 0, 32'h0); wr(3, 2, 32'hFFFF_FFFF);
    wr(15, 0, 32'hFFFF_FFFF); wr(5, 0, 32'hFFFF_FFFF);
    rd(2, 0, d); chk("R10 mask unchanged", d, 32'hFFFF_0BDF);
    rd(5, 0, d); chk("R10 sens unchanged", d, 0);
    rd(2, 2, d); chk("R10 out-of-range word reads 0", d, 0);
    rd(0, 0, d); chk("R10 status unchanged", d, 0);

    // Random phase: steady pins, random control traffic
    lineIn = N'({$urandom, $urandom});
    waitCyc(4);
    wr(1, 0, 32'hFFFF_FFFF); wr(1, 1, 32'hFFFF_FFFF);
    for (int i = 0; i < 200; i++) begin
      int kinds[10] = '{1, 3, 4, 6, 7, 9, 10, 12, 13, 14};
      int rdk[5] = '{2, 5, 8, 11, 14};
      int k = kinds[$urandom_range(0, 9)];
      int w = $urandom_range(0, NW);
      int rk = rdk[$urandom_range(0, 4)];
      logic [N-1:0] st;
      logic [N-1:0] mv;
      wr(k, w, $urandom);
      st = modelStatus();
      for (int x = 0; x < NW; x++) begin
        rd(0, x, d); chk("R4/R7/R8 random status", d, wordOf(st, x));
      end
      chk("R9 random irq", irqOut, |(st & ~mMask));
      case (rk)
        2: mv = mMask; 5: mv = mSens; 8: mv = mPol; 11: mv = mSoft; default: mv = mDom;
      endcase
      rd(rk, w % NW, d); chk("R3 random readback", d, wordOf(mv, w % NW));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule